// File: doc/BRIEF.md
# Background and Overlay Video Mixer

The mixer builds one output pixel stream from three sources and stacks them from the bottom up. The bottom is a solid black background whose width and height come from configuration inputs. The middle is a video layer taken from the processing pipeline. The top is an overlay layer that is always blended at one half over whatever lies beneath it. Each layer occupies a programmable rectangle, set by an x/y offset and a size, inside the background. Outside that rectangle the layer leaves the pixel below it unchanged.

The background generator sets the output frames. Output pixels leave in raster order, with a start-of-frame flag on the first pixel and an end-of-frame flag on the last. The video layer is shown only while the `video_stable` input reports that live input video is present. If that input falls, the video layer drops out at once, and the output goes on showing background and overlay with unbroken framing. This keeps the display steady while a source is unplugged or plugged back in.

Configuration is sampled at each output frame boundary. Both layer streams use valid/ready handshakes with their own frame flags. Each layer frame is aligned to the output through its start-of-frame pixel. A layer that is switched off is drained so that it never backs up its source.

Top module: `layer_mixer`

## Requirements
- R1: Each output frame has (cfg_bg_wm1+1)×(cfg_bg_hm1+1) pixels in raster order. `out_sof` is high on exactly the first pixel of a frame and `out_eof` on exactly the last. Both size inputs hold the size minus one.
- R2: A pixel that no shown layer covers is black, which is all 24 bits zero.
- R3: Inside the video rectangle, with video shown, no overlay covering the pixel and the video frame not yet ended, the output equals the next video pixel in raster order.
- R4: Where an overlay pixel covers the position, each 8-bit component ([23:16], [15:8], [7:0]) of the output is (under + over + 1) >> 1. Here "under" is the video pixel or black.
- R5: Video is shown only if cfg_vid_en was high and video_stable was high when the frame started. If video_stable falls in the middle of a frame, video disappears from the very next output pixel. It stays hidden for the rest of that frame even if video_stable rises again.
- R6: The configuration inputs in force for a frame are those present when the frame's first pixel is transferred. Changes made during the frame have no effect until the next frame.
- R7: While a layer that the current pixel needs has no valid pixel, out_valid is low. While out_ready is low, a layer that is in the middle of its frame is not consumed.
- R8: A layer that is switched off for the current frame has its ready held high, so its pixels are drained and discarded.
- R9: Pixels a layer presents before its start-of-frame pixel are discarded. The start-of-frame pixel is placed at the layer rectangle's top-left corner.
- R10: Once a layer has delivered its end-of-frame pixel, the rest of its rectangle in that output frame is transparent, and no further pixels of that layer are taken until the next output frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bg_wm1 | input | XW | Background width minus one |
| cfg_bg_hm1 | input | XW | Background height minus one |
| cfg_vid_en | input | 1 | Video layer enable |
| cfg_vid_x | input | XW | Video rectangle left column |
| cfg_vid_y | input | XW | Video rectangle top row |
| cfg_vid_wm1 | input | XW | Video rectangle width minus one |
| cfg_vid_hm1 | input | XW | Video rectangle height minus one |
| cfg_ovl_en | input | 1 | Overlay layer enable |
| cfg_ovl_x | input | XW | Overlay rectangle left column |
| cfg_ovl_y | input | XW | Overlay rectangle top row |
| cfg_ovl_wm1 | input | XW | Overlay rectangle width minus one |
| cfg_ovl_hm1 | input | XW | Overlay rectangle height minus one |
| video_stable | input | 1 | High while live input video is present |
| vid_valid | input | 1 | Video pixel valid |
| vid_ready | output | 1 | Video pixel accepted or drained |
| vid_data | input | 3*CW | Video pixel |
| vid_sof | input | 1 | Video start of frame |
| vid_eof | input | 1 | Video end of frame |
| ovl_valid | input | 1 | Overlay pixel valid |
| ovl_ready | output | 1 | Overlay pixel accepted or drained |
| ovl_data | input | 3*CW | Overlay pixel |
| ovl_sof | input | 1 | Overlay start of frame |
| ovl_eof | input | 1 | Overlay end of frame |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Output pixel accepted |
| out_data | output | 3*CW | Output pixel |
| out_sof | output | 1 | Output start of frame |
| out_eof | output | 1 | Output end of frame |

## Verification
Two events can land in one cycle: a loss of video stability and the frame-boundary sample of the configuration. The bench drives video_stable low in the same cycle that a new frame's settings are applied. It also drops the signal at a random pixel in the middle of a frame and raises it again four pixels later. The expected image is worked out per pixel from the frame's settings and from the pixel index at which stability fell. A second overlap happens when the overlay blend sits on a video pixel while either stream is stalling. Random valid gaps and out_ready gaps produce it, and every transferred pixel is compared with the blended value predicted by the bench.

// File: rtl/layer_mixer.sv
module layer_mixer #(
  parameter int CW = 8,
  parameter int XW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] cfg_bg_wm1,
  input  logic [XW-1:0] cfg_bg_hm1,
  input  logic          cfg_vid_en,
  input  logic [XW-1:0] cfg_vid_x,
  input  logic [XW-1:0] cfg_vid_y,
  input  logic [XW-1:0] cfg_vid_wm1,
  input  logic [XW-1:0] cfg_vid_hm1,
  input  logic          cfg_ovl_en,
  input  logic [XW-1:0] cfg_ovl_x,
  input  logic [XW-1:0] cfg_ovl_y,
  input  logic [XW-1:0] cfg_ovl_wm1,
  input  logic [XW-1:0] cfg_ovl_hm1,
  input  logic          video_stable,
  input  logic          vid_valid,
  output logic          vid_ready,
  input  logic [3*CW-1:0] vid_data,
  input  logic          vid_sof,
  input  logic          vid_eof,
  input  logic          ovl_valid,
  output logic          ovl_ready,
  input  logic [3*CW-1:0] ovl_data,
  input  logic          ovl_sof,
  input  logic          ovl_eof,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [3*CW-1:0] out_data,
  output logic          out_sof,
  output logic          out_eof
);
  localparam int PW  = 3*CW;
  localparam int RW  = 4*XW;
  localparam int CFW = 2*XW + 2*RW + 2;

  typedef enum logic [1:0] {L_SEEK, L_LIVE, L_DONE} lstate_t;

  logic [CFW-1:0] cfg_now, cfg_lat, cfg_cur;
  logic [XW-1:0]  px, py, bg_w, bg_h;
  logic [RW-1:0]  rect [2];
  logic [PW-1:0]  ld [2];
  logic [PW-1:0]  under, mixed;
  logic [1:0]     on, lv, ls, le, lrdy, need, ok;
  logic           at0, eol, fire;

  assign cfg_now = {cfg_bg_wm1, cfg_bg_hm1,
                    cfg_vid_x, cfg_vid_y, cfg_vid_wm1, cfg_vid_hm1,
                    cfg_ovl_x, cfg_ovl_y, cfg_ovl_wm1, cfg_ovl_hm1,
                    cfg_vid_en, cfg_ovl_en};
  assign at0     = (px == '0) && (py == '0);
  assign cfg_cur = at0 ? cfg_now : cfg_lat;
  assign bg_w    = cfg_cur[CFW-1 -: XW];
  assign bg_h    = cfg_cur[CFW-1-XW -: XW];
  assign rect[0] = cfg_cur[2+RW +: RW];
  assign rect[1] = cfg_cur[2 +: RW];
  assign on      = {cfg_cur[0], cfg_cur[1] & video_stable};

  assign lv    = {ovl_valid, vid_valid};
  assign ls    = {ovl_sof, vid_sof};
  assign le    = {ovl_eof, vid_eof};
  assign ld[0] = vid_data;
  assign ld[1] = ovl_data;
  assign vid_ready = lrdy[0];
  assign ovl_ready = lrdy[1];

  assign out_valid = &ok;
  assign fire      = out_valid && out_ready;
  assign eol       = (px == bg_w);
  assign out_eof   = eol && (py == bg_h);
  assign out_sof   = at0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      px      <= '0;
      py      <= '0;
      cfg_lat <= '0;
    end else begin
      if (fire) begin
        if (eol) begin
          px <= '0;
          py <= out_eof ? '0 : py + 1'b1;
        end else begin
          px <= px + 1'b1;
        end
        if (at0) cfg_lat <= cfg_now;
      end
      if (!video_stable) cfg_lat[1] <= 1'b0;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_layer
    logic [XW-1:0] rx, ry, rw, rh;
    logic          inr;
    lstate_t       st;

    assign {rx, ry, rw, rh} = rect[g];
    assign inr = (px >= rx) && ({1'b0, px} <= {1'b0, rx} + {1'b0, rw}) &&
                 (py >= ry) && ({1'b0, py} <= {1'b0, ry} + {1'b0, rh});
    assign need[g] = on[g] && inr && (st != L_DONE);
    assign ok[g]   = !need[g] || (lv[g] && (st == L_LIVE || ls[g]));
    assign lrdy[g] = !on[g] || (st == L_SEEK && !ls[g]) || (fire && need[g]);

    always_ff @(posedge clk) begin
      if (!rst_n)                st <= L_SEEK;
      else if (fire && out_eof)  st <= L_SEEK;
      else if (fire && need[g])  st <= le[g] ? L_DONE : L_LIVE;
    end

    p_live_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_ready && on[g] && st == L_LIVE) |-> !lrdy[g]);
    p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == L_DONE && on[g]) |-> !lrdy[g]);
  end

  assign under = need[0] ? ld[0] : '0;

  for (genvar c = 0; c < 3; c++) begin : g_comp
    logic [CW-1:0] u, o;
    logic [CW:0]   s;
    assign u = under[c*CW +: CW];
    assign o = ld[1][c*CW +: CW];
    assign s = {1'b0, u} + {1'b0, o} + 1'b1;
    assign mixed[c*CW +: CW] = s[CW:1];

    p_blend_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && need[1]) |->
        (out_data[c*CW +: CW] >= ((u < o) ? u : o)) &&
        (out_data[c*CW +: CW] <= ((u < o) ? o : u)));
  end

  assign out_data = need[1] ? mixed : under;

  p_sof_after_eof_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_eof) |=> out_sof);
  p_no_mid_sof_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !out_eof) |=> !out_sof);
  p_black_bg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && need == 2'b00) |-> (out_data == '0));
  p_unstable_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !video_stable |-> vid_ready);
endmodule

// File: tb/layer_mixer_tb.sv
`timescale 1ns/100ps
module layer_mixer_tb;
  localparam int NF = 24;

  logic clk = 0;
  logic rst_n = 0;
  always #2.5 clk = ~clk;

  logic [11:0] cfg_bg_wm1, cfg_bg_hm1;
  logic        cfg_vid_en, cfg_ovl_en;
  logic [11:0] cfg_vid_x, cfg_vid_y, cfg_vid_wm1, cfg_vid_hm1;
  logic [11:0] cfg_ovl_x, cfg_ovl_y, cfg_ovl_wm1, cfg_ovl_hm1;
  logic        video_stable = 1;
  logic        lv [2];
  logic        ls [2];
  logic        le [2];
  logic [23:0] ld [2];
  logic        lr [2];
  logic        out_valid, out_sof, out_eof;
  logic        out_ready = 0;
  logic [23:0] out_data;

  layer_mixer u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_bg_wm1(cfg_bg_wm1), .cfg_bg_hm1(cfg_bg_hm1),
    .cfg_vid_en(cfg_vid_en), .cfg_vid_x(cfg_vid_x), .cfg_vid_y(cfg_vid_y),
    .cfg_vid_wm1(cfg_vid_wm1), .cfg_vid_hm1(cfg_vid_hm1),
    .cfg_ovl_en(cfg_ovl_en), .cfg_ovl_x(cfg_ovl_x), .cfg_ovl_y(cfg_ovl_y),
    .cfg_ovl_wm1(cfg_ovl_wm1), .cfg_ovl_hm1(cfg_ovl_hm1),
    .video_stable(video_stable),
    .vid_valid(lv[0]), .vid_ready(lr[0]), .vid_data(ld[0]), .vid_sof(ls[0]), .vid_eof(le[0]),
    .ovl_valid(lv[1]), .ovl_ready(lr[1]), .ovl_data(ld[1]), .ovl_sof(ls[1]), .ovl_eof(le[1]),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof)
  );

  int bw[NF], bh[NF], vx[NF], vy[NF], vw[NF], vh[NF], ox[NF], oy[NF], ow[NF], oh[NF];
  int vl[NF], ol[NF], vj[NF], oj[NF], ve[NF], oe[NF], md[NF], dp[NF], scr[NF];
  int n_tests = 0, n_fail = 0, frames_done = 0;
  bit finished = 0;

  task automatic chk(input bit good, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] pix(input int L, input int f, input int k);
    logic [7:0] a, b, c;
    a = 8'(f*37 + k*11 + L*91 + 5);
    b = 8'(k*53 + f*7 + L);
    c = 8'(k*7 + L*5 + f*3 + 100);
    return {a, b, c};
  endfunction

  function automatic bit inr(input int x, input int y, input int rx, input int ry, input int rw, input int rh);
    return (x >= rx) && (x <= rx + rw) && (y >= ry) && (y <= ry + rh);
  endfunction

  task automatic expect_px(input int f, input int idx, input bit live,
                           output logic [23:0] e, output string tag);
    int x, y, k;
    logic [23:0] u, o;
    x = idx % (bw[f] + 1);
    y = idx / (bw[f] + 1);
    u = '0;
    tag = "R2";
    if (inr(x, y, vx[f], vy[f], vw[f], vh[f])) begin
      k = (y - vy[f]) * (vw[f] + 1) + (x - vx[f]);
      if (ve[f] == 0) tag = "R8";
      else if (md[f] == 2 || !live) tag = "R5";
      else if (k < vl[f]) begin u = pix(0, f, k); tag = (vj[f] > 0) ? "R9" : "R3"; end
      else tag = "R10";
    end
    e = u;
    if (oe[f] != 0 && inr(x, y, ox[f], oy[f], ow[f], oh[f])) begin
      k = (y - oy[f]) * (ow[f] + 1) + (x - ox[f]);
      if (k < ol[f]) begin
        o = pix(1, f, k);
        for (int c = 0; c < 3; c++)
          e[c*8 +: 8] = 8'((int'(u[c*8 +: 8]) + int'(o[c*8 +: 8]) + 1) / 2);
        tag = "R4";
      end else tag = "R10";
    end
    if (scr[f] != 0) tag = "R6";
  endtask

  task automatic apply_cfg(input int f);
    cfg_bg_wm1 = 12'(bw[f]); cfg_bg_hm1 = 12'(bh[f]);
    cfg_vid_en = ve[f] != 0; cfg_ovl_en = oe[f] != 0;
    cfg_vid_x = 12'(vx[f]); cfg_vid_y = 12'(vy[f]); cfg_vid_wm1 = 12'(vw[f]); cfg_vid_hm1 = 12'(vh[f]);
    cfg_ovl_x = 12'(ox[f]); cfg_ovl_y = 12'(oy[f]); cfg_ovl_wm1 = 12'(ow[f]); cfg_ovl_hm1 = 12'(oh[f]);
  endtask

  task automatic scramble();
    cfg_bg_wm1 = 12'($urandom % 9); cfg_bg_hm1 = 12'($urandom % 9);
    cfg_vid_en = 1'($urandom); cfg_ovl_en = 1'($urandom);
    cfg_vid_x = 12'($urandom % 5); cfg_vid_y = 12'($urandom % 5);
    cfg_vid_wm1 = 12'($urandom % 5); cfg_vid_hm1 = 12'($urandom % 5);
    cfg_ovl_x = 12'($urandom % 5); cfg_ovl_y = 12'($urandom % 5);
    cfg_ovl_wm1 = 12'($urandom % 5); cfg_ovl_hm1 = 12'($urandom % 5);
  endtask

  task automatic drive_px(input int L, input logic [23:0] d, input logic s, input logic e);
    bit done = 0;
    while (!done) begin
      @(negedge clk);
      lv[L] = ($urandom % 4) != 0;
      ld[L] = d; ls[L] = s; le[L] = e;
      #1;
      done = lv[L] && lr[L];
    end
  endtask

  task automatic run_layer(input int L);
    int len, junk;
    wait (rst_n);
    for (int f = 0; f < NF; f++) begin
      wait (frames_done >= f);
      if (L == 0 && f == 0) repeat (20) @(negedge clk);
      junk = (L == 0) ? vj[f] : oj[f];
      len  = (L == 0) ? vl[f] : ol[f];
      for (int j = 0; j < junk; j++) drive_px(L, 24'($urandom), 1'b0, 1'b0);
      for (int k = 0; k < len; k++) drive_px(L, pix(L, f, k), k == 0, k == len - 1);
      @(negedge clk);
      lv[L] = 0;
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    int rs, npix;
    void'($urandom(32'h1F2E3D4C));
    for (int f = 0; f < NF; f++) begin
      bw[f] = 2 + int'($urandom % 14);
      bh[f] = 1 + int'($urandom % 7);
      vw[f] = (f == 0) ? bw[f] : int'($urandom % (bw[f] + 1));
      vh[f] = (f == 0) ? bh[f] : int'($urandom % (bh[f] + 1));
      vx[f] = (f == 0) ? 0 : int'($urandom % (bw[f] - vw[f] + 1));
      vy[f] = (f == 0) ? 0 : int'($urandom % (bh[f] - vh[f] + 1));
      ow[f] = int'($urandom % (bw[f] + 1));
      oh[f] = int'($urandom % (bh[f] + 1));
      ox[f] = int'($urandom % (bw[f] - ow[f] + 1));
      oy[f] = int'($urandom % (bh[f] - oh[f] + 1));
      ve[f] = (f == 0) ? 1 : int'(($urandom % 4) != 0);
      oe[f] = (f == 0) ? 0 : int'(($urandom % 4) != 0);
      vj[f] = (f == 0) ? 0 : int'($urandom % 3);
      oj[f] = int'($urandom % 3);
      rs = (vw[f] + 1) * (vh[f] + 1);
      vl[f] = (f == 0) ? rs : rs + int'($urandom % 5) - 3;
      if (vl[f] < 1) vl[f] = 1;
      rs = (ow[f] + 1) * (oh[f] + 1);
      ol[f] = rs + int'($urandom % 5) - 3;
      if (ol[f] < 1) ol[f] = 1;
      md[f] = (f % 6 == 3) ? 1 : (f % 6 == 5) ? 2 : 0;
      npix = (bw[f] + 1) * (bh[f] + 1);
      dp[f] = 1 + int'($urandom % (npix - 2));
      scr[f] = int'(f % 4 == 2);
    end
    for (int L = 0; L < 2; L++) begin lv[L] = 0; ls[L] = 0; le[L] = 0; ld[L] = '0; end
    apply_cfg(0);
  end

  initial run_layer(0);
  initial run_layer(1);

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", frames_done, NF);
      summary();
      $finish;
    end
  end

  initial begin
    int idx, f, npix;
    bit live, pnext, pscr;
    int pdrop;
    logic [23:0] e;
    string tag;
    idx = 0; live = 1; pnext = 0; pscr = 0; pdrop = 0;
    repeat (4) @(negedge clk);
    #1;
    chk(out_sof == 1'b1, "R1", 32'(out_sof), 32'd1);
    @(negedge clk);
    rst_n = 1;
    out_ready = 1;
    repeat (15) begin
      @(negedge clk);
      #1;
      chk(out_valid == 1'b0, "R7", 32'(out_valid), 32'd0);
    end
    while (frames_done < NF) begin
      @(negedge clk);
      if (pscr) begin scramble(); pscr = 0; end
      if (pdrop == 1) begin video_stable = 0; live = 0; end
      else if (pdrop == 2) video_stable = 1;
      pdrop = 0;
      if (pnext) begin
        pnext = 0; idx = 0; live = 1;
        if (frames_done + 1 < NF) begin
          apply_cfg(frames_done + 1);
          video_stable = (md[frames_done + 1] == 2) ? 1'b0 : 1'b1;
        end
        frames_done++;
        if (frames_done == NF) break;
      end
      out_ready = ($urandom % 4) != 0;
      #1;
      f = frames_done;
      npix = (bw[f] + 1) * (bh[f] + 1);
      if (scr[f] == 0 && (ve[f] == 0 || md[f] == 2))
        chk(lr[0] == 1'b1, "R8", 32'(lr[0]), 32'd1);
      if (scr[f] == 0 && oe[f] == 0)
        chk(lr[1] == 1'b1, "R8", 32'(lr[1]), 32'd1);
      if (f == 0 && lv[0] && !out_ready)
        chk(lr[0] == 1'b0, "R7", 32'(lr[0]), 32'd0);
      if (out_valid && out_ready) begin
        expect_px(f, idx, live, e, tag);
        chk(out_data == e, tag, 32'(out_data), 32'(e));
        chk({out_sof, out_eof} == {idx == 0, idx == npix - 1}, "R1",
            32'({out_sof, out_eof}), 32'({idx == 0, idx == npix - 1}));
        if (md[f] == 1 && idx == dp[f]) pdrop = 1;
        if (md[f] == 1 && idx == dp[f] + 4) pdrop = 2;
        if (scr[f] != 0 && idx == 2) pscr = 1;
        if (idx == npix - 1) pnext = 1;
        idx++;
      end
    end
    finished = 1;
    summary();
    $finish;
  end
endmodule